// File: doc/BRIEF.md
# Data TLB Lookup with Access Fault Checking

This block is a fully associative data translation buffer paired with a permission stage. Software-side logic loads entries through a write port: a virtual page, a context, a physical page and a 64-bit translation attribute word. A lookup presents a virtual page, a context, an access kind and a user-mode flag. Every entry is compared at once. The matching entry's attributes are then checked against the access.

The result comes back one clock after the request. On a clean hit it carries the physical page and the read and write grants. On a fault it carries a trap code and a fault-status word. The fault-type bits in that word list every cause found, not just the first one.

The permission stage also handles nonfaulting loads. A page marked no-fault-only accepts only nonfaulting loads. A page marked side-effect refuses them. A store to a page that is not writable raises a protection trap, but only when no access-exception cause is present. The reserved access-kind value 3 is handled as a plain load.

Top module: `dtlb_fault_chk`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every entry is invalid, so any lookup misses.
- R2: `rsp_valid` is high in the cycle after a cycle with `lk_req` high. It is low after a cycle without a request. Each request gives exactly one result strobe.
- R3: A hit needs three things: attribute bit 63 (valid) set, an equal virtual page and an equal context. Otherwise the result is a miss (`rsp_miss`=1, `rsp_hit`=0, `rsp_trap`=0, `rsp_fsr[4:2]`=0, no grants, `rsp_ppn`=0).
- R4: A lookup with `lk_user`=1 that hits an entry with attribute bit 2 (privileged) set gives `rsp_trap`=1 (access exception) and sets `rsp_fsr[2]`.
- R5: A nonfaulting load (`lk_kind`=2) that hits an entry with attribute bit 3 (side-effect) set gives `rsp_trap`=1 and sets `rsp_fsr[3]`.
- R6: Any access other than a nonfaulting load that hits an entry with attribute bit 60 (no-fault-only) set gives `rsp_trap`=1 and sets `rsp_fsr[4]`.
- R7: The R4, R5 and R6 causes are judged independently. When several apply, all their `rsp_fsr` bits are set in the same result.
- R8: A store (`lk_kind`=1) that hits an entry with attribute bit 1 (writable) clear gives `rsp_trap`=2 (protection), with `rsp_fsr[4:2]`=0. This applies only when no R4 to R6 cause applies; otherwise the trap is 1.
- R9: For every result, hit or miss, `rsp_fsr[0]` is 1 exactly for a store and `rsp_fsr[1]` is 1 exactly for a nonfaulting load. Access kinds are encoded load=0, store=1, nonfaulting load=2.
- R10: A hit with no fault gives `rsp_trap`=0, `rsp_rd_ok`=1, `rsp_wr_ok` equal to attribute bit 1, and `rsp_ppn` equal to the entry's physical page. On any fault both grants are 0 and `rsp_ppn` is 0.
- R11: When several valid entries match, the lowest index wins. A write replaces the entry at `wr_idx`, and lookups issued in later cycles see the new contents.
- R12: Attribute bits 41 (used), 6 (locked) and 0 (global) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | VPN_W | Virtual page tag to store |
| wr_ctx | input | CTX_W | Context tag to store |
| wr_ppn | input | PPN_W | Physical page to store |
| wr_tte | input | 64 | Attribute word to store |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_ctx | input | CTX_W | Lookup context |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 nonfaulting load |
| lk_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | Result strobe, one cycle per request |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_trap | output | 2 | 0 none, 1 access exception, 2 protection |
| rsp_fsr | output | 5 | [0] store, [1] nonfaulting, [2] privilege, [3] side-effect, [4] no-fault-only |
| rsp_rd_ok | output | 1 | Read granted |
| rsp_wr_ok | output | 1 | Write granted |
| rsp_ppn | output | PPN_W | Translated physical page |

## Verification
On every cycle, the bound checker enforces several invariants:
- The strobe timing follows each request.
- A miss never carries a trap, a fault-type bit or a grant.
- A protection trap never comes with fault-type bits.
- The side-effect cause appears only with the nonfaulting flag, and the no-fault-only cause only without it.
- A write grant implies a clean read grant.
- An access-exception condition seen at the lookup becomes trap code 1 on the next cycle.

Other properties can only be shown by the bench's scenarios. These are the exact fault-status value for each combination of attribute flags, access kind and privilege, the lowest-index priority among duplicate matches, the effect of overwriting an entry, and the fact that the used, locked and global bits do not matter.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // attribute word flag positions (behaviour depends on these)
  localparam int TTE_W       = 64;
  localparam int TTE_VALID   = 63;
  localparam int TTE_NFO     = 60;
  localparam int TTE_USED    = 41;
  localparam int TTE_LOCKED  = 6;
  localparam int TTE_SIDEFX  = 3;
  localparam int TTE_PRIV    = 2;
  localparam int TTE_WRITE   = 1;
  localparam int TTE_GLOBAL  = 0;

  // access kinds
  localparam logic [1:0] ACC_LOAD   = 2'd0;
  localparam logic [1:0] ACC_STORE  = 2'd1;
  localparam logic [1:0] ACC_NFLOAD = 2'd2;

  // trap codes
  localparam logic [1:0] TRAP_NONE    = 2'd0;
  localparam logic [1:0] TRAP_DACCESS = 2'd1;
  localparam logic [1:0] TRAP_DPROT   = 2'd2;

  // fault-status layout
  localparam int FSR_W       = 5;
  localparam int FSR_STORE   = 0;
  localparam int FSR_NF      = 1;
  localparam int FSR_FT_PRIV = 2;
  localparam int FSR_FT_SE   = 3;
  localparam int FSR_FT_NFO  = 4;
  localparam int FT_W        = 3;

  // cause vector: [0] privilege, [1] side-effect on nf load, [2] nfo page
  function automatic logic [FT_W-1:0] fault_causes(input logic [TTE_W-1:0] tte,
                                                   input logic [1:0] kind,
                                                   input logic user);
    logic nf;
    nf = (kind == ACC_NFLOAD);
    fault_causes[0] = user & tte[TTE_PRIV];
    fault_causes[1] = nf & tte[TTE_SIDEFX];
    fault_causes[2] = ~nf & tte[TTE_NFO];
  endfunction

  // access-kind flags: [0] store, [1] nonfaulting load
  function automatic logic [1:0] access_flags(input logic [1:0] kind);
    access_flags = {kind == ACC_NFLOAD, kind == ACC_STORE};
  endfunction

endpackage

// File: rtl/dtlb_entry_array.sv
module dtlb_entry_array
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int CTX_W   = 13,
  parameter int PPN_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [TTE_W-1:0] wr_tte,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  output logic             hit_any,
  output logic [TTE_W-1:0] sel_tte,
  output logic [PPN_W-1:0] sel_ppn
);

  logic [ENTRIES-1:0] match_vec;
  logic [TTE_W-1:0]   ent_tte [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] vpn_r;
    logic [CTX_W-1:0] ctx_r;
    logic [PPN_W-1:0] ppn_r;
    logic [TTE_W-1:0] tte_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_r <= '0;
        ctx_r <= '0;
        ppn_r <= '0;
        tte_r <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        vpn_r <= wr_vpn;
        ctx_r <= wr_ctx;
        ppn_r <= wr_ppn;
        tte_r <= wr_tte;
      end
    end

    assign match_vec[g] = tte_r[TTE_VALID] && (vpn_r == lk_vpn) && (ctx_r == lk_ctx);
    assign ent_tte[g]   = tte_r;
    assign ent_ppn[g]   = ppn_r;
  end

  // lowest index wins: scan downward so the last assignment is the lowest match
  always_comb begin
    sel_tte = '0;
    sel_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel_tte = ent_tte[i];
        sel_ppn = ent_ppn[i];
      end
    end
  end

  assign hit_any = |match_vec;

endmodule

// File: rtl/dtlb_perm_check.sv
module dtlb_perm_check
  import dtlb_pkg::*;
(
  input  logic [TTE_W-1:0] tte,
  input  logic [1:0]       kind,
  input  logic             user,
  output logic [FT_W-1:0]  causes,
  output logic [1:0]       acc,
  output logic             dae_cond,
  output logic             prot_cond,
  output logic             rd_ok,
  output logic             wr_ok
);

  assign causes    = fault_causes(tte, kind, user);
  assign acc       = access_flags(kind);
  assign dae_cond  = |causes;
  assign prot_cond = ~dae_cond & (kind == ACC_STORE) & ~tte[TTE_WRITE];
  assign rd_ok     = ~dae_cond & ~prot_cond;
  assign wr_ok     = rd_ok & tte[TTE_WRITE];

endmodule

// File: rtl/dtlb_fault_chk.sv
module dtlb_fault_chk
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int CTX_W   = 13,
  parameter int PPN_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [63:0]      wr_tte,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic [1:0]       lk_kind,
  input  logic             lk_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [1:0]       rsp_trap,
  output logic [4:0]       rsp_fsr,
  output logic             rsp_rd_ok,
  output logic             rsp_wr_ok,
  output logic [PPN_W-1:0] rsp_ppn
);

  // named internal events (also observed by the bound checker)
  logic             hit_any;
  logic [TTE_W-1:0] sel_tte;
  logic [PPN_W-1:0] sel_ppn;
  logic [FT_W-1:0]  causes;
  logic [1:0]       acc;
  logic             dae_cond;
  logic             prot_cond;
  logic             pc_rd_ok;
  logic             pc_wr_ok;

  dtlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .PPN_W(PPN_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ctx(wr_ctx),
    .wr_ppn(wr_ppn), .wr_tte(wr_tte),
    .lk_vpn(lk_vpn), .lk_ctx(lk_ctx),
    .hit_any(hit_any), .sel_tte(sel_tte), .sel_ppn(sel_ppn)
  );

  dtlb_perm_check u_perm (
    .tte(sel_tte), .kind(lk_kind), .user(lk_user),
    .causes(causes), .acc(acc), .dae_cond(dae_cond), .prot_cond(prot_cond),
    .rd_ok(pc_rd_ok), .wr_ok(pc_wr_ok)
  );

  logic [1:0]       trap_d;
  logic [4:0]       fsr_d;
  logic             grant_d;

  always_comb begin
    grant_d = hit_any & pc_rd_ok;
    fsr_d   = {(hit_any ? causes : '0), acc};
    if (!hit_any)       trap_d = TRAP_NONE;
    else if (dae_cond)  trap_d = TRAP_DACCESS;
    else if (prot_cond) trap_d = TRAP_DPROT;
    else                trap_d = TRAP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_trap  <= TRAP_NONE;
      rsp_fsr   <= '0;
      rsp_rd_ok <= 1'b0;
      rsp_wr_ok <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit   <= hit_any;
        rsp_miss  <= ~hit_any;
        rsp_trap  <= trap_d;
        rsp_fsr   <= fsr_d;
        rsp_rd_ok <= grant_d;
        rsp_wr_ok <= grant_d & pc_wr_ok;
        rsp_ppn   <= grant_d ? sel_ppn : '0;
      end
    end
  end

endmodule

// File: rtl/dtlb_fault_chk_sva.sv
module dtlb_fault_chk_sva
  import dtlb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       lk_req,
  input logic       hit_any,
  input logic       dae_cond,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_miss,
  input logic [1:0] rsp_trap,
  input logic [4:0] rsp_fsr,
  input logic       rsp_rd_ok,
  input logic       rsp_wr_ok
);

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));

  // R3
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_trap == TRAP_NONE && rsp_fsr[4:2] == 3'b000
                                 && !rsp_rd_ok && !rsp_wr_ok));

  // R4
  dae_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && hit_any && dae_cond) |=> (rsp_trap == TRAP_DACCESS));

  // R7
  cause_means_dae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fsr[4:2] != 3'b000) |-> (rsp_trap == TRAP_DACCESS));

  // R5
  se_only_nf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fsr[FSR_FT_SE]) |-> rsp_fsr[FSR_NF]);

  // R6
  nfo_not_nf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fsr[FSR_FT_NFO]) |-> !rsp_fsr[FSR_NF]);

  // R8
  prot_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap == TRAP_DPROT) |-> (rsp_fsr[4:2] == 3'b000 && rsp_fsr[FSR_STORE]));

  // R9
  kind_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fsr[FSR_STORE] && rsp_fsr[FSR_NF]));

  // R10
  grant_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_ok) |-> (rsp_rd_ok && rsp_trap == TRAP_NONE));

endmodule

bind dtlb_fault_chk dtlb_fault_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .hit_any(hit_any),
  .dae_cond(dae_cond), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_trap(rsp_trap), .rsp_fsr(rsp_fsr),
  .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
);

// File: tb/dtlb_fault_chk_tb.sv
module dtlb_fault_chk_tb;

  localparam int ENTRIES = 64;
  localparam int VPN_W   = 20;
  localparam int CTX_W   = 13;
  localparam int PPN_W   = 24;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [VPN_W-1:0] wr_vpn = '0;
  logic [CTX_W-1:0] wr_ctx = '0;
  logic [PPN_W-1:0] wr_ppn = '0;
  logic [63:0]      wr_tte = '0;
  logic             lk_req = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [CTX_W-1:0] lk_ctx = '0;
  logic [1:0]       lk_kind = '0;
  logic             lk_user = 1'b0;
  logic             rsp_valid, rsp_hit, rsp_miss, rsp_rd_ok, rsp_wr_ok;
  logic [1:0]       rsp_trap;
  logic [4:0]       rsp_fsr;
  logic [PPN_W-1:0] rsp_ppn;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dtlb_fault_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .PPN_W(PPN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_ctx(wr_ctx), .wr_ppn(wr_ppn), .wr_tte(wr_tte), .lk_req(lk_req),
    .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .lk_kind(lk_kind), .lk_user(lk_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_trap(rsp_trap), .rsp_fsr(rsp_fsr), .rsp_rd_ok(rsp_rd_ok),
    .rsp_wr_ok(rsp_wr_ok), .rsp_ppn(rsp_ppn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_tte(input logic v, input logic nfo, input logic se,
                                         input logic pr, input logic w, input logic junk);
    logic [63:0] t;
    t = '0;
    t[63] = v; t[60] = nfo; t[3] = se; t[2] = pr; t[1] = w;
    t[41] = junk; t[6] = junk; t[0] = junk;
    return t;
  endfunction

  // packed result view: {hit, miss, trap, fsr, rd, wr, ppn}
  function automatic logic [63:0] got();
    return 64'({rsp_hit, rsp_miss, rsp_trap, rsp_fsr, rsp_rd_ok, rsp_wr_ok, rsp_ppn});
  endfunction

  // expected result for a hit, from the requirement text
  function automatic logic [63:0] expect_hit(input logic nfo, input logic se, input logic pr,
                                             input logic w, input logic [1:0] kind,
                                             input logic user, input logic [PPN_W-1:0] ppn);
    logic st, nf, c_pr, c_se, c_nfo, exc, prot, ok;
    logic [1:0] trap;
    st    = (kind == 2'd1);
    nf    = (kind == 2'd2);
    c_pr  = pr && user;
    c_se  = se && nf;
    c_nfo = nfo && !nf;
    exc   = (int'(c_pr) + int'(c_se) + int'(c_nfo)) > 0;
    prot  = !exc && st && !w;
    trap  = exc ? 2'd1 : (prot ? 2'd2 : 2'd0);
    ok    = (trap == 2'd0);
    return 64'({1'b1, 1'b0, trap, c_nfo, c_se, c_pr, nf, st, ok, ok && w,
                (ok ? ppn : {PPN_W{1'b0}})});
  endfunction

  function automatic logic [63:0] expect_miss(input logic [1:0] kind);
    return 64'({1'b0, 1'b1, 2'd0, 3'b000, kind == 2'd2, kind == 2'd1, 1'b0, 1'b0,
                {PPN_W{1'b0}}});
  endfunction

  task automatic put(input int idx, input logic [VPN_W-1:0] v, input logic [CTX_W-1:0] c,
                     input logic [PPN_W-1:0] p, input logic [63:0] t);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn = v; wr_ctx = c; wr_ppn = p; wr_tte = t;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive a request for one cycle; returns at the negedge where the result is visible
  task automatic look(input logic [VPN_W-1:0] v, input logic [CTX_W-1:0] c,
                      input logic [1:0] kind, input logic user);
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = v; lk_ctx = c; lk_kind = kind; lk_user = user;
    @(negedge clk);
    lk_req = 1'b0;
    chk("R2 strobe", 64'(rsp_valid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid after reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    look(20'h0, 13'h0, 2'd0, 1'b0);
    chk("R1 empty miss", got(), expect_miss(2'd0));
    @(negedge clk);
    chk("R2 strobe drops", 64'(rsp_valid), 64'd0);

    // R4..R10 sweep: flags x kind x user
    for (int c = 0; c < 96; c++) begin
      logic [3:0] fl;
      logic [1:0] kind;
      logic user;
      logic [VPN_W-1:0] v;
      logic [CTX_W-1:0] cx;
      logic [PPN_W-1:0] p;
      logic [63:0] e;
      string tag;
      fl   = 4'(c);
      kind = 2'((c / 16) % 3);
      user = (c >= 48);
      v    = VPN_W'(20'h100 + c);
      cx   = CTX_W'(c + 1);
      p    = PPN_W'(24'hA000 + c * 7);
      put(c % ENTRIES, v, cx, p, mk_tte(1'b1, fl[3], fl[2], fl[1], fl[0], 1'b0));
      look(v, cx, kind, user);
      e = expect_hit(fl[3], fl[2], fl[1], fl[0], kind, user, p);
      if ($countones(e[PPN_W+6:PPN_W+4]) > 1) tag = "R7 multi-cause";
      else if (e[PPN_W+4]) tag = "R4 privilege";
      else if (e[PPN_W+5]) tag = "R5 side-effect";
      else if (e[PPN_W+6]) tag = "R6 no-fault-only";
      else if (e[PPN_W+8:PPN_W+7] == 2'd2) tag = "R8 protection";
      else tag = "R10 clean hit";
      chk(tag, got(), e);
      chk("R9 kind flags", 64'(rsp_fsr[1:0]), 64'({kind == 2'd2, kind == 2'd1}));
    end

    // R3 miss variants
    put(10, 20'h5555, 13'h0AA, 24'h123456, mk_tte(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    look(20'h5554, 13'h0AA, 2'd1, 1'b0);
    chk("R3 vpn mismatch", got(), expect_miss(2'd1));
    look(20'h5555, 13'h0AB, 2'd2, 1'b0);
    chk("R3 ctx mismatch", got(), expect_miss(2'd2));
    put(11, 20'h6666, 13'h0BB, 24'h222222, mk_tte(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    look(20'h6666, 13'h0BB, 2'd0, 1'b0);
    chk("R3 invalid entry", got(), expect_miss(2'd0));
    look(20'h5555, 13'h0AA, 2'd1, 1'b0);
    chk("R10 store grant", got(), expect_hit(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 24'h123456));

    // R11 priority and overwrite
    put(5, 20'h7777, 13'h011, 24'h000555, mk_tte(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    put(9, 20'h7777, 13'h011, 24'h000999, mk_tte(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    look(20'h7777, 13'h011, 2'd0, 1'b0);
    chk("R11 lowest index", got(), expect_hit(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 24'h000555));
    put(5, 20'h7778, 13'h011, 24'h000555, mk_tte(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    look(20'h7777, 13'h011, 2'd1, 1'b0);
    chk("R11 overwrite", got(), expect_hit(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 24'h000999));

    // R12 used/locked/global have no effect
    for (int k = 0; k < 3; k++) begin
      put(20, 20'h8888, 13'h022, 24'h0C0C0C, mk_tte(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1));
      look(20'h8888, 13'h022, 2'(k), 1'b1);
      chk("R12 ignored bits", got(),
          expect_hit(1'b1, 1'b1, 1'b1, 1'b0, 2'(k), 1'b1, 24'h0C0C0C));
    end
    put(21, 20'h9999, 13'h033, 24'h0D0D0D, mk_tte(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    look(20'h9999, 13'h033, 2'd1, 1'b0);
    chk("R12 ignored bits clean", got(),
        expect_hit(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 24'h0D0D0D));

    // R2 back-to-back requests each strobe once
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = 20'h9999; lk_ctx = 13'h033; lk_kind = 2'd0; lk_user = 1'b0;
    @(negedge clk);
    chk("R2 first of pair", 64'(rsp_valid), 64'd1);
    lk_vpn = 20'h1234;
    @(negedge clk);
    lk_req = 1'b0;
    chk("R2 second of pair", got(), expect_miss(2'd0));
    @(negedge clk);
    chk("R2 idle after pair", 64'(rsp_valid), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule